// File: doc/BRIEF.md
# Clocked Sequencer for an Asynchronous Byte-Wide Static RAM

This block sits between a synchronous user port and an external asynchronous static RAM of 524,288 bytes. The RAM has a 19-bit address, an 8-bit data bus and three active-low strobes: select, write and output enable. The user offers one access at a time with a valid/ready handshake. The access carries an address, a direction flag and, for writes, a data byte. The block then plays out the strobe sequence on the memory pins. Every phase lasts a whole number of clock cycles. The number of cycles is the ceiling of a memory time limit divided by the clock period. Read data comes back on a one-cycle response pulse.

The memory data bus is shared. Toward the pad it is split into an output byte, an output-enable and an input byte. The block switches its own drivers on only while the memory cannot be driving. After a read, it also waits out the memory's worst-case release time before it drives write data. All time limits are parameters in picoseconds, so a slower speed grade or a different clock needs only new parameter values.

Top module: `sram_seq_ctrl`

## Requirements
- R1: After reset, all three strobes (`mem_ce_n`, `mem_we_n`, `mem_oe_n`) are high, `mem_dq_oe` is low, `req_ready` is high and `rsp_valid` is low.
- R2: `req_ready` is high only while no access is in progress. When it is high, all three strobes are high. It goes low in the cycle after a request is accepted and stays low until the access has finished (15 cycles for a read or for a write with no pending turnaround, at the default parameters).
- R3: For a read, `mem_ce_n` and `mem_oe_n` are low together and `mem_we_n` stays high.
  - At the default parameters (5 ns clock, 70 ns access), this lasts exactly 14 cycles.
  - The memory input byte is captured on the edge that ends this phase.
- R4: Each read produces exactly one `rsp_valid` pulse, one cycle long. `rsp_rdata` equals the byte last written to that address.
- R5: For a write, the sequence runs in this order:
  - `mem_ce_n` goes low at least one cycle before `mem_we_n` falls.
  - `mem_we_n` then stays low for exactly 13 cycles at the defaults. This is the largest of the pulse, data-overlap, address-to-end and select-to-end limits.
  - `mem_we_n` rises at least one hold cycle before `mem_ce_n` rises, the address changes or the data drivers turn off.
- R6: `mem_dq_oe` is never high while `mem_oe_n` is low.
- R7: Address and write data are stable for as long as `mem_ce_n` is low.
- R8: After a read releases the strobes, `mem_dq_oe` stays low for at least 8 cycles at the defaults. This is the worst-case bus release time of 40 ns.
- R9: `mem_we_n` is low only while `mem_ce_n` is low.
- R10: All 19 address bits reach the memory. Bytes written at address 0x00000 and at address 0x7FFFF stay distinct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, accepts a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 8 | Read byte |
| mem_addr | output | 19 | Memory address pins |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_out | output | 8 | Byte driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the data pad drivers |
| mem_dq_in | input | 8 | Byte read from the data pads |

## Verification
The assertions assume that the user holds `req_valid` and its payload steady until acceptance. They also assume that `mem_dq_in` matters only in the capture cycle of a read.

The bench drives each request at a falling edge while `req_ready` is high. It then removes the request right after acceptance, so a request never changes while it is pending. Its memory model presents read data only while select and output enable are both low. It stores a byte on the rising edge of the write strobe.

// File: rtl/sram_seq_pkg.sv
`timescale 1ns/1ps
package sram_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_RD       = 3'd1,
      ST_RD_HOLD  = 3'd2,
      ST_WR_SETUP = 3'd3,
      ST_WR_PULSE = 3'd4,
      ST_WR_HOLD  = 3'd5
   } seq_state_e;

   // whole cycles covering a time span, rounded up
   function automatic int cyc_ceil(input int span_ps, input int clk_ps);
      return (span_ps + clk_ps - 1) / clk_ps;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_phase_cnt.sv
`timescale 1ns/1ps
// Down counter that times one phase of the access sequence.
module sram_phase_cnt #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load)         cnt_q <= load_val;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_bus_guard.sv
`timescale 1ns/1ps
// Holds off the data drivers until the memory has surely released the bus.
module sram_bus_guard #(
   parameter int HOLD_CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   output logic bus_free
);
   if (HOLD_CYC < 0) begin : g_bad_hold
      $error("HOLD_CYC must not be negative");
   end

   if (HOLD_CYC == 0) begin : g_no_wait
      assign bus_free = 1'b1;
   end else begin : g_wait
      localparam int GW = $clog2(HOLD_CYC + 1);
      logic [GW-1:0] wait_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              wait_q <= '0;
         else if (arm)            wait_q <= GW'(HOLD_CYC);
         else if (wait_q != '0)   wait_q <= wait_q - 1'b1;
      end

      assign bus_free = (wait_q == '0) && !arm;
   end
endmodule

// File: rtl/sram_seq_ctrl.sv
`timescale 1ns/1ps
module sram_seq_ctrl
   import sram_seq_pkg::*;
#(
   parameter int ADDR_W    = 19,
   parameter int DATA_W    = 8,
   parameter int CLK_PS    = 5000,
   parameter int T_RC_PS   = 70000,
   parameter int T_AA_PS   = 70000,
   parameter int T_CO_PS   = 70000,
   parameter int T_OE_PS   = 40000,
   parameter int T_WC_PS   = 70000,
   parameter int T_WP_PS   = 50000,
   parameter int T_AW_PS   = 65000,
   parameter int T_CW_PS   = 65000,
   parameter int T_DW_PS   = 30000,
   parameter int T_AH_PS   = 5000,
   parameter int T_OHZ_PS  = 25000,
   parameter int T_CHZ_PS  = 40000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);
   // phase lengths in cycles
   localparam int RD_CYC  = imax(1, cyc_ceil(imax(imax(T_RC_PS, T_AA_PS),
                                  imax(T_CO_PS, T_OE_PS)), CLK_PS));
   localparam int AH_CYC  = imax(1, cyc_ceil(T_AH_PS, CLK_PS));
   localparam int WP_MIN  = cyc_ceil(imax(imax(T_WP_PS, T_DW_PS),
                                  imax(T_AW_PS, T_CW_PS)), CLK_PS);
   localparam int WP_CYC  = imax(1, imax(WP_MIN, cyc_ceil(T_WC_PS, CLK_PS) - 1 - AH_CYC));
   localparam int TA_CYC  = cyc_ceil(imax(T_OHZ_PS, T_CHZ_PS), CLK_PS);
   localparam int CNT_W   = $clog2(imax(RD_CYC, imax(WP_CYC, AH_CYC)) + 1);

   if (CLK_PS <= 0) begin : g_bad_clk
      $error("CLK_PS must be positive");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("ADDR_W and DATA_W must be at least 1");
   end

   seq_state_e            st_q, st_d;
   logic [ADDR_W-1:0]     addr_q;
   logic [DATA_W-1:0]     wdata_q;
   logic                  phase_done;
   logic                  bus_free;
   logic                  ph_load;
   logic [CNT_W-1:0]      ph_val;
   logic                  accept;

   assign accept = req_valid && (st_q == ST_IDLE);

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:     if (req_valid) st_d = req_write ? ST_WR_SETUP : ST_RD;
         ST_RD:       if (phase_done) st_d = ST_RD_HOLD;
         ST_RD_HOLD:  if (phase_done) st_d = ST_IDLE;
         ST_WR_SETUP: if (phase_done && bus_free) st_d = ST_WR_PULSE;
         ST_WR_PULSE: if (phase_done) st_d = ST_WR_HOLD;
         ST_WR_HOLD:  if (phase_done) st_d = ST_IDLE;
         default:     st_d = ST_IDLE;
      endcase
   end

   always_comb begin
      ph_load = (st_d != st_q);
      unique case (st_d)
         ST_RD:       ph_val = CNT_W'(RD_CYC - 1);
         ST_RD_HOLD,
         ST_WR_HOLD:  ph_val = CNT_W'(AH_CYC - 1);
         ST_WR_PULSE: ph_val = CNT_W'(WP_CYC - 1);
         default:     ph_val = '0;
      endcase
   end

   sram_phase_cnt #(.CNT_W(CNT_W)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ph_load),
      .load_val (ph_val),
      .expired  (phase_done)
   );

   sram_bus_guard #(.HOLD_CYC(TA_CYC)) u_guard (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm      (st_q == ST_RD && st_d == ST_RD_HOLD),
      .bus_free (bus_free)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         addr_q    <= '0;
         wdata_q   <= '0;
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         st_q      <= st_d;
         rsp_valid <= (st_q == ST_RD) && phase_done;
         if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
         end
         if ((st_q == ST_RD) && phase_done) rsp_rdata <= mem_dq_in;
      end
   end

   // pin decode from the state register
   assign req_ready  = (st_q == ST_IDLE);
   assign mem_addr   = addr_q;
   assign mem_dq_out = wdata_q;
   assign mem_ce_n   = !(st_q == ST_RD || st_q == ST_WR_SETUP ||
                         st_q == ST_WR_PULSE || st_q == ST_WR_HOLD);
   assign mem_oe_n   = (st_q != ST_RD);
   assign mem_we_n   = (st_q != ST_WR_PULSE);
   assign mem_dq_oe  = (st_q == ST_WR_PULSE) || (st_q == ST_WR_HOLD);

   // ---------------- assertions ----------------
   a_r2_idle_strobes_high: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

   a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   a_r6_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);

   a_r7_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

   a_r9_we_inside_ce: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> !mem_ce_n);

   a_r5_hold_after_we: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (!mem_ce_n && mem_dq_oe));

   a_r3_read_we_high: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> (mem_we_n && !mem_ce_n));

endmodule

// File: tb/sram_seq_ctrl_tb.sv
`timescale 1ns/1ps
module sram_seq_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [18:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        rsp_valid;
   logic [7:0]  rsp_rdata;
   logic [18:0] mem_addr;
   logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [7:0]  mem_dq_out;
   logic [7:0]  mem_dq_in = 8'h00;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   sram_seq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
      .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
      .mem_dq_in(mem_dq_in)
   );

   // memory model and pin monitors, all sampled at falling edges
   logic [7:0] mem [int];
   logic prev_we = 1'b1, prev_oe = 1'b1;
   int we_run = 0, last_we_run = 0;
   int oe_run = 0, last_oe_run = 0;
   int since_rel = 1000, gap_at_drive = 1000;
   logic prev_oe_drv = 1'b0;
   int contention = 0, we_outside_ce = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_we == 1'b0 && mem_we_n == 1'b1 && mem_ce_n == 1'b0)
            mem[int'(mem_addr)] = mem_dq_out;
         if (!mem_we_n) we_run++;
         else if (!prev_we) begin last_we_run = we_run; we_run = 0; end
         if (!mem_oe_n) oe_run++;
         else if (!prev_oe) begin last_oe_run = oe_run; oe_run = 0; end
         if (!prev_oe && mem_oe_n) since_rel = 0;
         else if (since_rel < 1000) since_rel++;
         if (mem_dq_oe && !prev_oe_drv) gap_at_drive = since_rel;
         if (mem_dq_oe && !mem_oe_n) contention++;
         if (!mem_we_n && mem_ce_n) we_outside_ce++;
         prev_we = mem_we_n;
         prev_oe = mem_oe_n;
         prev_oe_drv = mem_dq_oe;
      end
      if (!mem_ce_n && !mem_oe_n && mem_we_n)
         mem_dq_in = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'hEE;
      else
         mem_dq_in = 8'h00;
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic check_ge(input string req, input int act, input int lim);
      checks++;
      if (act < lim) begin
         errors++;
         $display("FAIL %s actual=%0d expected>=%0d", req, act, lim);
      end
   endtask

   task automatic access(input bit wr, input logic [18:0] a, input logic [7:0] d,
                         output int busy, output int pulses, output logic [7:0] rd);
      busy = 0; pulses = 0; rd = 8'h00;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      while (!req_ready) begin
         if (rsp_valid) begin pulses++; rd = rsp_rdata; end
         busy++;
         @(negedge clk);
      end
   endtask

   task automatic t_reset;
      @(negedge clk);
      check("R1 ce_n", int'(mem_ce_n), 1);
      check("R1 we_n", int'(mem_we_n), 1);
      check("R1 oe_n", int'(mem_oe_n), 1);
      check("R1 dq_oe", int'(mem_dq_oe), 0);
      check("R1 ready", int'(req_ready), 1);
      check("R1 rsp_valid", int'(rsp_valid), 0);
   endtask

   task automatic t_write_basic;
      int b, p; logic [7:0] r;
      access(1'b1, 19'h00123, 8'hA5, b, p, r);
      check("R2 write busy cycles", b, 15);
      check("R5 we_n low cycles", last_we_run, 13);
      check("R5 write no response", p, 0);
   endtask

   task automatic t_read_basic;
      int b, p; logic [7:0] r;
      access(1'b0, 19'h00123, 8'h00, b, p, r);
      check("R2 read busy cycles", b, 15);
      check("R3 oe_n low cycles", last_oe_run, 14);
      check("R4 response pulses", p, 1);
      check("R4 read data", int'(r), 8'hA5);
   endtask

   task automatic t_turnaround;
      int b, p; logic [7:0] r;
      access(1'b0, 19'h00123, 8'h00, b, p, r);
      access(1'b1, 19'h00456, 8'h3C, b, p, r);
      check_ge("R8 drive gap after read", gap_at_drive, 8);
      check("R5 we_n low after turnaround", last_we_run, 13);
      access(1'b0, 19'h00456, 8'h00, b, p, r);
      check("R4 read after turnaround", int'(r), 8'h3C);
   endtask

   task automatic t_addr_extremes;
      int b, p; logic [7:0] r;
      access(1'b1, 19'h00000, 8'h11, b, p, r);
      access(1'b1, 19'h7FFFF, 8'hEE ^ 8'h77, b, p, r);
      access(1'b0, 19'h00000, 8'h00, b, p, r);
      check("R10 low address", int'(r), 8'h11);
      access(1'b0, 19'h7FFFF, 8'h00, b, p, r);
      check("R10 high address", int'(r), 8'h99);
   endtask

   task automatic t_pattern;
      int b, p; logic [7:0] r;
      for (int i = 0; i < 4; i++)
         access(1'b1, 19'(32'h40000 + i * 32'h1111), 8'(8'h5A + i * 8'h21), b, p, r);
      for (int i = 3; i >= 0; i--) begin
         access(1'b0, 19'(32'h40000 + i * 32'h1111), 8'h00, b, p, r);
         check("R4 pattern read", int'(r), int'(8'(8'h5A + i * 8'h21)));
      end
   endtask

   bit finished = 1'b0;

   initial begin
      #(200000 * 5);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_write_basic();
      t_read_basic();
      t_turnaround();
      t_addr_extremes();
      t_pattern();
      check("R6 driver against memory output", contention, 0);
      check("R9 write strobe outside select", we_outside_ce, 0);
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule